// File: doc/BRIEF.md
# Approximate Unsigned Multiplier with Error Recovery

This block multiplies two unsigned N-bit operands and returns a 2N-bit product that is close to the exact one but is built for a short critical path. The partial products are formed with AND gates, one row per multiplier bit, each shifted into place. The rows are then summed in a binary tree of approximate adders. Each tree level halves the operand count. Each approximate adder cuts its carry chain after one bit and reports every position where it dropped a carry in an error vector.

The error vectors are masked to the K most significant positions and merged into one compensation vector. A parameter picks the merge method. With variant 1 the error bits are ORed together, which is cheap. With variant 2 they are folded through a chain of the same approximate adders, which is more accurate. A single exact adder then adds the compensation vector to the tree result. The datapath is combinational. An optional output register, cleared by reset, retimes the product by one clock.

The block suits error-tolerant signal processing, where a small error in the low-order product bits is acceptable in exchange for speed and power. It is instantiated with the operand width, the recovery depth K, the merge variant and the register option set at design time.

Top module: `amul_top`

## Requirements
- R1: The product is 2N bits wide. It equals the tree sum plus the compensation vector, added exactly, modulo 2^(2N).
- R2: In each approximate adder, position i makes a carry only when both input bits at i are 1, and that carry reaches only position i+1. When position i+1 has exactly one input bit set and receives such a carry, the sum bit there is 1 and the error bit there is 1. In every other case the error bit is 0.
- R3: The N partial product rows are summed in a tree of N-1 adders arranged in log2(N) levels, each level halving the operand count. The raw tree sum never exceeds the exact product.
- R4: Error bits below the K most significant product positions are dropped. With K = 0 the product equals the raw tree sum.
- R5: If either operand is zero, the product is zero.
- R6: The product never exceeds the exact product.
- R7: If the multiplier operand b has exactly one bit set, the product is exact.
- R8: With OUT_REG = 1, the product for the operands present at a rising clock edge appears after that edge. While reset is low, the product output is zero. With OUT_REG = 0, the output follows the operands combinationally.
- R9: With VARIANT = 1, the masked error vectors are ORed together. With VARIANT = 2, they are combined left to right, in adder-index order (level by level, lowest index first), through the approximate adder of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low synchronous reset of the output register |
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| prod_o | output | 2N | Approximate product |

## Verification
The assertions assume that both operands are driven to known values from the first clock edge after reset onward. They also assume the operands change only between clock edges, so the registered product can be related to the operands one edge earlier. The bench drives the operands to zero from time zero and changes them only on falling edges. It sweeps every operand pair of the 8×8 configuration, so the zero-operand and single-bit-multiplier corner cases are covered exhaustively. It also runs a K = 0 instance and an OR-recovery instance alongside the default one.

// File: rtl/amul_pkg.sv
package amul_pkg;
   // merge variants for the error compensation vector
   localparam int unsigned RECOVER_OR  = 1;
   localparam int unsigned RECOVER_ADD = 2;
endpackage

// File: rtl/amul_ppgen.sv
module amul_ppgen #(
   parameter int unsigned N = 8,
   localparam int unsigned W = 2 * N
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   output logic [W-1:0] pp_o [0:N-1]
);
   // one AND row per multiplier bit, shifted to its weight
   for (genvar r = 0; r < N; r++) begin : g_row
      logic [W-1:0] row_ext;
      assign row_ext  = {{N{1'b0}}, (a_i & {N{b_i[r]}})};
      assign pp_o[r]  = row_ext << r;
   end
endmodule

// File: rtl/amul_approx_add.sv
module amul_approx_add #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] s_o,
   output logic [W-1:0] e_o
);
   logic [W-1:0] half;
   logic [W-1:0] gen_up;

   initial begin
      if (W < 2) $error("amul_approx_add: W must be at least 2");
   end

   // carry is born only from a generate and moves up exactly one place
   assign half   = x_i ^ y_i;
   assign gen_up = {x_i[W-2:0] & y_i[W-2:0], 1'b0};
   assign s_o    = half | gen_up;
   assign e_o    = half & gen_up;
endmodule

// File: rtl/amul_tree.sv
module amul_tree #(
   parameter int unsigned N = 8,
   localparam int unsigned W = 2 * N,
   localparam int unsigned NADD = N - 1,
   localparam int unsigned NNODE = 2 * N - 1
) (
   input  logic [W-1:0] pp_i  [0:N-1],
   output logic [W-1:0] sum_o,
   output logic [W-1:0] err_o [0:NADD-1]
);
   // nodes 0..N-1 are leaves; adder j reads nodes 2j, 2j+1 and writes node N+j
   logic [W-1:0] node [0:NNODE-1];

   for (genvar i = 0; i < N; i++) begin : g_leaf
      assign node[i] = pp_i[i];
   end

   for (genvar j = 0; j < NADD; j++) begin : g_add
      amul_approx_add #(.W(W)) u_add (
         .x_i (node[2*j]),
         .y_i (node[2*j+1]),
         .s_o (node[N+j]),
         .e_o (err_o[j])
      );
   end

   assign sum_o = node[NNODE-1];
endmodule

// File: rtl/amul_err_merge.sv
module amul_err_merge #(
   parameter int unsigned N = 8,
   parameter int unsigned K = 8,
   parameter int unsigned VARIANT = amul_pkg::RECOVER_ADD,
   localparam int unsigned W = 2 * N,
   localparam int unsigned NADD = N - 1
) (
   input  logic [W-1:0] err_i [0:NADD-1],
   output logic [W-1:0] comp_o
);
   localparam logic [W-1:0] KEEP = ~({W{1'b1}} >> K);

   logic [W-1:0] masked [0:NADD-1];

   for (genvar j = 0; j < NADD; j++) begin : g_mask
      assign masked[j] = err_i[j] & KEEP;
   end

   function automatic logic [W-1:0] fold_sum(input logic [W-1:0] x, input logic [W-1:0] y);
      logic [W-1:0] g;
      g = {x[W-2:0] & y[W-2:0], 1'b0};
      return (x ^ y) | g;
   endfunction

   if (VARIANT == amul_pkg::RECOVER_OR) begin : g_or
      always_comb begin
         comp_o = '0;
         for (int j = 0; j < NADD; j++) comp_o = comp_o | masked[j];
      end
   end else begin : g_chain
      logic [W-1:0] acc [0:NADD-1];
      assign acc[0] = masked[0];
      for (genvar j = 1; j < NADD; j++) begin : g_step
         assign acc[j] = fold_sum(acc[j-1], masked[j]);
      end
      assign comp_o = acc[NADD-1];
   end
endmodule

// File: rtl/amul_top.sv
module amul_top #(
   parameter int unsigned N = 8,
   parameter int unsigned K = 8,
   parameter int unsigned VARIANT = amul_pkg::RECOVER_ADD,
   parameter bit OUT_REG = 1'b1,
   localparam int unsigned W = 2 * N,
   localparam int unsigned NADD = N - 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   output logic [W-1:0] prod_o
);
   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      initial $error("amul_top: N must be a power of two, at least 2");
   end
   if (K > W) begin : g_bad_k
      initial $error("amul_top: K must not exceed 2N");
   end
   if (VARIANT != amul_pkg::RECOVER_OR && VARIANT != amul_pkg::RECOVER_ADD) begin : g_bad_v
      initial $error("amul_top: VARIANT must be 1 or 2");
   end

   logic [W-1:0] pp       [0:N-1];
   logic [W-1:0] err      [0:NADD-1];
   logic [W-1:0] tree_sum;
   logic [W-1:0] comp;
   logic [W-1:0] prod_nxt;

   amul_ppgen #(.N(N)) u_ppgen (
      .a_i  (a_i),
      .b_i  (b_i),
      .pp_o (pp)
   );

   amul_tree #(.N(N)) u_tree (
      .pp_i  (pp),
      .sum_o (tree_sum),
      .err_o (err)
   );

   amul_err_merge #(.N(N), .K(K), .VARIANT(VARIANT)) u_merge (
      .err_i  (err),
      .comp_o (comp)
   );

   // single exact carry-propagate addition
   assign prod_nxt = tree_sum + comp;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (!rst_ni) prod_o <= '0;
         else         prod_o <= prod_nxt;
      end
   end else begin : g_comb
      assign prod_o = prod_nxt;
   end
endmodule

// File: rtl/amul_chk.sv
module amul_chk #(
   parameter int unsigned N = 8,
   parameter int unsigned K = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int unsigned W = 2 * N
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic [N-1:0] a_i,
   input logic [N-1:0] b_i,
   input logic [W-1:0] prod_o,
   input logic [W-1:0] tree_sum,
   input logic [W-1:0] comp
);
   localparam logic [W-1:0] KEEP = ~({W{1'b1}} >> K);

   logic [W-1:0] exact;
   assign exact = {{N{1'b0}}, a_i} * {{N{1'b0}}, b_i};

   // R3: tree sum bounded by exact product
   p_tree_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tree_sum <= exact);

   // R4: no compensation below the recovered window
   p_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (comp & ~KEEP) == '0);

   if (OUT_REG) begin : g_seq
      p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (a_i == '0 || b_i == '0) |=> prod_o == '0);
      p_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         rst_ni |=> prod_o <= $past(exact));
      p_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($countones(b_i) == 1) |=> prod_o == $past(exact));
   end else begin : g_cmb
      p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (a_i == '0 || b_i == '0) |-> prod_o == '0);
      p_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         prod_o <= exact);
      p_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($countones(b_i) == 1) |-> prod_o == exact);
   end
endmodule

bind amul_top amul_chk #(.N(N), .K(K), .OUT_REG(OUT_REG)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .a_i      (a_i),
   .b_i      (b_i),
   .prod_o   (prod_o),
   .tree_sum (tree_sum),
   .comp     (comp)
);

// File: tb/tb_amul_top.sv
module tb_amul_top;
   localparam int N = 8;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] a = '0;
   logic [N-1:0] b = '0;
   logic [W-1:0] prod_add, prod_or, prod_raw;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   real med_sum = 0.0;

   always #10 clk = ~clk;

   // default: K=8, chained-adder recovery, registered
   amul_top #(.N(N), .K(8), .VARIANT(2), .OUT_REG(1'b1)) dut (
      .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .prod_o(prod_add));
   // full-window OR recovery, combinational
   amul_top #(.N(N), .K(16), .VARIANT(1), .OUT_REG(1'b0)) dut_or (
      .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .prod_o(prod_or));
   // no recovery, combinational
   amul_top #(.N(N), .K(0), .VARIANT(2), .OUT_REG(1'b0)) dut_raw (
      .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .prod_o(prod_raw));

   // bitwise rule of R2
   function automatic logic [W-1:0] m_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                          output logic [W-1:0] e);
      logic [W-1:0] s;
      logic cin;
      for (int i = 0; i < W; i++) begin
         cin = (i > 0) ? (x[i-1] & y[i-1]) : 1'b0;
         if (x[i] != y[i]) begin s[i] = 1'b1; e[i] = cin; end
         else begin s[i] = cin; e[i] = 1'b0; end
      end
      return s;
   endfunction

   function automatic logic [W-1:0] model(input logic [N-1:0] x, input logic [N-1:0] y,
                                          input int variant, input int k);
      logic [W-1:0] ops [0:N-1];
      logic [W-1:0] errs [0:N-2];
      logic [W-1:0] e, keep, acc, tmp;
      int cnt, ne;
      keep = '0;
      for (int i = 0; i < k; i++) keep[W-1-i] = 1'b1;
      for (int r = 0; r < N; r++) ops[r] = y[r] ? (W'(x) << r) : '0;
      cnt = N; ne = 0;
      while (cnt > 1) begin
         for (int j = 0; j < cnt / 2; j++) begin
            tmp = m_add(ops[2*j], ops[2*j+1], e);
            ops[j] = tmp;
            errs[ne] = e & keep;
            ne++;
         end
         cnt = cnt / 2;
      end
      acc = errs[0];
      for (int j = 1; j < N - 1; j++) begin
         if (variant == 1) acc = acc | errs[j];
         else acc = m_add(acc, errs[j], e);
      end
      return ops[0] + acc;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] ex;
      repeat (3) @(posedge clk);
      @(negedge clk);
      a = 8'hFF; b = 8'hFF;
      @(posedge clk); @(negedge clk);
      check("R8 reset clears product", prod_add, '0);
      rst_n = 1'b1;
      for (int ia = 0; ia < 256; ia++) begin
         for (int ib = 0; ib < 256; ib++) begin
            a = N'(ia); b = N'(ib);
            @(posedge clk); @(negedge clk);
            ex = W'(ia * ib);
            check("R1 R2 R3 R9 variant2 K=8 registered (R8)", prod_add, model(a, b, 2, 8));
            check("R9 variant1 OR K=16", prod_or, model(a, b, 1, 16));
            check("R4 K=0 raw tree sum", prod_raw, model(a, b, 2, 0));
            if (ia == 0 || ib == 0) check("R5 zero operand", prod_add, '0);
            if ($countones(b) == 1) check("R7 single-bit multiplier exact", prod_or, ex);
            if (prod_add > ex) check("R6 bounded by exact", prod_add, ex);
            if (prod_raw > ex) check("R3 tree sum bounded", prod_raw, ex);
            med_sum += real'(ex - prod_add);
         end
      end
      $display("mean error distance (K=8, variant 2): %f", med_sum / 65536.0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule